// File: doc/BRIEF.md
# Asynchronous Bus Cycle Sequencer

This block is the master side of a read transfer on an asynchronous bus. A request with an address starts a cycle that walks through eight bus states, one clock each (S0 to S7). The block drives an active-low address strobe and waits for the slave to terminate the cycle. The slave does this through a level-sensitive, active-low acknowledge or through an active-low bus-error line. Both lines pass through a flip-flop synchronizer, and the machine looks at them in exactly one state, S4.

When acknowledge is recognized, the read data is registered at the end of S6. A one-clock done pulse in S7 presents the data together with a valid flag. If neither line is low when sampled, the machine adds wait states in pairs until a later sample sees one of them. A slave that ties acknowledge low gets back-to-back cycles with no wait states. A slave that pulses acknowledge once lets the master advance one cycle at a time.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset the sequencer is idle: `as_n_o` is high, `done_o` is low, `valid_o` is low and `rdata_o` is zero.
- R2: A high `req_i` while idle or in S7 starts S0 at the next clock edge (counted as edge 0 of the cycle). `addr_i` is captured at that edge and `addr_o` holds it for the whole cycle.
- R3: `as_n_o` is low from S2 through S6, including every wait state. It is high in idle, S0, S1 and S7.
- R4: Acknowledge is level-sensitive and passes through a two-stage synchronizer before use. It is looked at only in S4. If the pin is low at edge 3 of a cycle, the cycle has no wait states and `done_o` is high in the clock after edge 7.
- R5: If S4 sees neither termination line low, one wait state follows and S4 repeats. Each repeat adds two clocks, so the sample at edge 5+2w uses the pin value at edge 3+2w and `done_o` follows edge 7+2w.
- R6: With acknowledge held low all the time and `req_i` held high, cycles run back to back every 8 clocks. Acknowledge never has to return high.
- R7: If acknowledge is low only around one sample and is then released, exactly one cycle completes. The next cycle stays in wait states until acknowledge is seen low again at a later sample.
- R8: On acknowledge termination, `data_i` present at the end of S6 is registered and appears on `rdata_o` while `done_o` is high.
- R9: `done_o` is high for exactly one clock per cycle, in S7.
- R10: A low bus-error input is sampled like acknowledge and ends the cycle with the same timing. In that case `valid_o` goes low and `rdata_o` keeps its previous value. If both lines are seen low in the same sample, bus error takes priority.
- R11: `valid_o` goes high on acknowledge termination and keeps its value until the next cycle terminates.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one bus state per clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Start a read cycle (level, held for back-to-back) |
| addr_i | input | AW | Address for the requested cycle |
| ack_n_i | input | 1 | Asynchronous active-low transfer acknowledge |
| berr_n_i | input | 1 | Asynchronous active-low bus error |
| data_i | input | DW | Read data from the slave |
| as_n_o | output | 1 | Active-low address strobe |
| addr_o | output | AW | Address of the cycle in progress |
| rdata_o | output | DW | Captured read data |
| valid_o | output | 1 | Last cycle ended by acknowledge |
| done_o | output | 1 | One-clock pulse in S7 |

## Verification
Every result is placed by counting edges from edge 0 of the cycle, which is the edge that enters S0. The strobe falls after edge 2. The termination sample at edge 5+2w looks at the pin value registered at edge 3+2w. Data, the valid flag and the done pulse all change at edge 7+2w. The bench computes w from the window in which it holds a termination line low, drives inputs on falling edges, and compares every output on every falling edge of the cycle against these positions. Wait-pair counts are swept over a range of acknowledge delays, and stepping, tied-low and bus-error cases reuse the same arithmetic.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int unsigned SYNC_STAGES = 2;

    typedef enum logic [3:0] {
        ST_IDLE = 4'd0,
        ST_S0   = 4'd1,
        ST_S1   = 4'd2,
        ST_S2   = 4'd3,
        ST_S3   = 4'd4,
        ST_S4   = 4'd5,
        ST_WT   = 4'd6,
        ST_S5   = 4'd7,
        ST_S6   = 4'd8,
        ST_S7   = 4'd9
    } bus_st_e;

    typedef struct packed {
        logic ack_n;
        logic berr_n;
    } term_lines_t;

    // strobe is driven low while the slave is being addressed
    function automatic logic strobe_active(bus_st_e s);
        return (s == ST_S2) || (s == ST_S3) || (s == ST_S4) ||
               (s == ST_WT) || (s == ST_S5) || (s == ST_S6);
    endfunction

    // a termination is seen when either active-low line is low
    function automatic logic term_seen(term_lines_t t);
        return !t.ack_n || !t.berr_n;
    endfunction

endpackage

// File: rtl/bcs_sync.sv
module bcs_sync #(
    parameter int unsigned WIDTH = 2,
    parameter int unsigned DEPTH = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [DEPTH-1:0][WIDTH-1:0] stg;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg <= RST_VAL;
                else     stg <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg <= {DEPTH{RST_VAL}};
                else     stg <= {stg[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout = stg[DEPTH-1];
endmodule

// File: rtl/bcs_fsm.sv
module bcs_fsm
    import bcs_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_i,
    input  term_lines_t term_s,
    output logic        addr_ld_o,
    output logic        cap_en_o,
    output logic        term_ok_o,
    output logic        as_n_o,
    output logic        done_o
);
    bus_st_e st_q, st_d;
    logic    ok_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: st_d = req_i ? ST_S0 : ST_IDLE;
            ST_S0:   st_d = ST_S1;
            ST_S1:   st_d = ST_S2;
            ST_S2:   st_d = ST_S3;
            ST_S3:   st_d = ST_S4;
            ST_S4:   st_d = term_seen(term_s) ? ST_S5 : ST_WT;
            ST_WT:   st_d = ST_S4;
            ST_S5:   st_d = ST_S6;
            ST_S6:   st_d = ST_S7;
            ST_S7:   st_d = req_i ? ST_S0 : ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
            ok_q <= 1'b0;
        end else begin
            st_q <= st_d;
            // bus error wins: the cycle is good only when berr is negated
            if (st_q == ST_S4 && term_seen(term_s))
                ok_q <= term_s.berr_n;
        end
    end

    assign addr_ld_o = req_i && (st_q == ST_IDLE || st_q == ST_S7);
    assign cap_en_o  = (st_q == ST_S6);
    assign term_ok_o = ok_q;
    assign as_n_o    = !strobe_active(st_q);
    assign done_o    = (st_q == ST_S7);

    p_start_r2: assert property (@(posedge clk) disable iff (rst)
        addr_ld_o |=> (st_q == ST_S0));

    p_sample_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_S4 && term_seen(term_s)) |=> (st_q == ST_S5));

    p_wait_pair_r5: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_S4 && !term_seen(term_s)) |=> (st_q == ST_WT) ##1 (st_q == ST_S4));

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    p_strobe_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(as_n_o) |-> done_o);
endmodule

// File: rtl/bcs_capture.sv
module bcs_capture #(
    parameter int unsigned AW = 24,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_ld_i,
    input  logic [AW-1:0] addr_i,
    input  logic          cap_en_i,
    input  logic          ok_i,
    input  logic [DW-1:0] data_i,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] rdata_o,
    output logic          valid_o
);
    logic [AW-1:0] addr_q;
    logic [DW-1:0] rdata_q;
    logic          valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            rdata_q <= '0;
            valid_q <= 1'b0;
        end else begin
            if (addr_ld_i) addr_q <= addr_i;
            if (cap_en_i) begin
                valid_q <= ok_i;
                if (ok_i) rdata_q <= data_i;
            end
        end
    end

    assign addr_o  = addr_q;
    assign rdata_o = rdata_q;
    assign valid_o = valid_q;

    p_capture_r8: assert property (@(posedge clk) disable iff (rst)
        (cap_en_i && ok_i) |=> (rdata_q == $past(data_i)) && valid_q);

    p_berr_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (cap_en_i && !ok_i) |=> $stable(rdata_q) && !valid_q);

    p_valid_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !cap_en_i |=> $stable(valid_q));
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int unsigned AW = 24,
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_i,
    input  logic [AW-1:0] addr_i,
    input  logic          ack_n_i,
    input  logic          berr_n_i,
    input  logic [DW-1:0] data_i,
    output logic          as_n_o,
    output logic [AW-1:0] addr_o,
    output logic [DW-1:0] rdata_o,
    output logic          valid_o,
    output logic          done_o
);
    localparam int unsigned TERM_W = $bits(term_lines_t);

    term_lines_t term_raw, term_s;
    logic        addr_ld, cap_en, term_ok;

    assign term_raw.ack_n  = ack_n_i;
    assign term_raw.berr_n = berr_n_i;

    bcs_sync #(
        .WIDTH   (TERM_W),
        .DEPTH   (SYNC_STAGES),
        .RST_VAL ({TERM_W{1'b1}})
    ) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (term_raw),
        .dout (term_s)
    );

    bcs_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .req_i     (req_i),
        .term_s    (term_s),
        .addr_ld_o (addr_ld),
        .cap_en_o  (cap_en),
        .term_ok_o (term_ok),
        .as_n_o    (as_n_o),
        .done_o    (done_o)
    );

    bcs_capture #(
        .AW (AW),
        .DW (DW)
    ) u_cap (
        .clk       (clk),
        .rst       (rst),
        .addr_ld_i (addr_ld),
        .addr_i    (addr_i),
        .cap_en_i  (cap_en),
        .ok_i      (term_ok),
        .data_i    (data_i),
        .addr_o    (addr_o),
        .rdata_o   (rdata_o),
        .valid_o   (valid_o)
    );
endmodule

// File: tb/test_bus_cycle_seq.sv
module test_bus_cycle_seq;
    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          ack_n_i = 1'b1;
    logic          berr_n_i = 1'b1;
    logic [DW-1:0] data_i = '0;
    logic          as_n_o, valid_o, done_o;
    logic [AW-1:0] addr_o;
    logic [DW-1:0] rdata_o;

    int n_vec = 0;
    int n_bad = 0;
    logic [DW-1:0] exp_rdata = '0;
    logic          exp_valid = 1'b0;

    always #10ns clk = ~clk;

    bus_cycle_seq #(.AW(AW), .DW(DW)) i_bus_cycle_seq (
        .clk(clk), .rst(rst), .req_i(req_i), .addr_i(addr_i),
        .ack_n_i(ack_n_i), .berr_n_i(berr_n_i), .data_i(data_i),
        .as_n_o(as_n_o), .addr_o(addr_o), .rdata_o(rdata_o),
        .valid_o(valid_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // mode 0: window on ack, 1: on bus error, 2: on both
    task automatic drive_pins(input int e, input int lo, input int hi, input int mode);
        bit low;
        low = (e >= lo) && (e < hi);
        ack_n_i  = !(low && mode != 1);
        berr_n_i = !(low && mode != 0);
    endtask

    task automatic idle_gap(input int k);
        for (int i = 0; i < k; i++) begin
            req_i = 1'b0; ack_n_i = 1'b1; berr_n_i = 1'b1;
            @(negedge clk);
            chk(as_n_o == 1'b1, "R3", "idle strobe", 32'(as_n_o), 32'd1);
            chk(done_o == 1'b0, "R9", "idle done", 32'(done_o), 32'd0);
        end
    endtask

    // one cycle; termination pin low for edges lo..hi-1 counted from edge 0
    task automatic run_cycle(input int lo, input int hi, input int mode, input bit keep,
                             input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input string tag);
        int w, last;
        w = -1;
        for (int k = 0; k < 64; k++) begin
            if (w < 0 && (3 + 2*k) >= lo && (3 + 2*k) < hi) w = k;
        end
        if (w < 0) begin
            chk(1'b0, tag, "bench window never sampled", 32'(lo), 32'(hi));
            return;
        end
        last = 7 + 2*w;
        req_i = 1'b1; addr_i = a; data_i = d;
        drive_pins(0, lo, hi, mode);
        for (int n = 0; n <= last; n++) begin
            @(negedge clk);
            // R2 address held; R3 strobe window; R4/R5 done position; R9 one pulse
            chk(addr_o == a, {tag, " R2"}, "addr", 32'(addr_o), 32'(a));
            chk(as_n_o == !(n >= 2 && n <= last - 1), {tag, " R3"}, "strobe",
                32'(as_n_o), 32'(!(n >= 2 && n <= last - 1)));
            chk(done_o == (n == last), {tag, " R4 R5 R9"}, "done",
                32'(done_o), 32'(n == last));
            if (n == last) begin
                if (mode == 0) begin
                    exp_rdata = d;
                    exp_valid = 1'b1;
                end else begin
                    exp_valid = 1'b0;
                end
            end
            // R8 data, R10 hold on bus error, R11 valid kept between terminations
            chk(rdata_o == exp_rdata, {tag, " R8 R10"}, "rdata",
                32'(rdata_o), 32'(exp_rdata));
            chk(valid_o == exp_valid, {tag, " R10 R11"}, "valid",
                32'(valid_o), 32'(exp_valid));
            if (n == last) begin
                if (!keep) req_i = 1'b0;
            end else begin
                drive_pins(n + 1, lo, hi, mode);
            end
        end
    endtask

    initial begin
        #4ms;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(as_n_o == 1'b1, "R1", "strobe", 32'(as_n_o), 32'd1);
        chk(done_o == 1'b0, "R1", "done", 32'(done_o), 32'd0);
        chk(valid_o == 1'b0, "R1", "valid", 32'(valid_o), 32'd0);
        chk(rdata_o == '0, "R1", "rdata", 32'(rdata_o), 32'd0);
        idle_gap(2);

        // R6 acknowledge tied low, back-to-back 8-clock cycles
        for (int c = 0; c < 4; c++)
            run_cycle(0, 100000, 0, c != 3, 24'h100 + 24'(c), 16'hA000 + 16'(c), "R6");
        idle_gap(3);

        // R4/R5 acknowledge delay sweep, held low once asserted
        for (int j = 0; j <= 14; j++) begin
            run_cycle(j, 100000, 0, 1'b0, 24'h2000 + 24'(j), 16'h5A00 ^ 16'(j * 37), "R5");
            idle_gap(2);
        end

        // R7 single-pulse stepping: one cycle, then a stall until the next pulse
        run_cycle(3, 4, 0, 1'b1, 24'h3001, 16'h1111, "R7");
        run_cycle(21, 22, 0, 1'b1, 24'h3002, 16'h2222, "R7");
        run_cycle(3, 4, 0, 1'b0, 24'h3003, 16'h3333, "R7");
        idle_gap(2);

        // R10 bus error termination over several delays, then both low together
        for (int j = 2; j <= 8; j += 3) begin
            run_cycle(j, 100000, 1, 1'b0, 24'h4000 + 24'(j), 16'hDEAD, "R10");
            idle_gap(2);
        end
        run_cycle(0, 100000, 0, 1'b0, 24'h5000, 16'hBEEF, "R11");
        idle_gap(2);
        run_cycle(3, 100000, 2, 1'b0, 24'h5001, 16'hC0DE, "R10");
        idle_gap(2);
        run_cycle(5, 100000, 0, 1'b0, 24'h5002, 16'h7777, "R11");
        idle_gap(2);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule